// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three independent counters, each 32 bits wide by default, behind a small word-addressed register bus. Each channel has its own register bank: a live count that software may overwrite, a reload value and two compare values. One shared control word turns each channel on. It also picks each channel's tick source, which is either every bus clock or each rising edge of that channel's external tick input. The same word enables each channel's wrap interrupt and sets the counting direction for all channels together.

Timer events are recorded in a shared sticky state register with three bits per channel. Software clears a state bit by writing 1 to it. A mask register stops chosen bits from driving the single combined interrupt line, but masked bits are still recorded. Typical uses are a periodic tick, where the channel counts down and reloads on wrap, and a free-running time base, where the reload is all ones. For a one-shot event, software programs compare 1 at the current count minus the wanted delay. The delay must be at least four ticks.

Top module: `tri_timer`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: Word index `bus_addr[7:2]` selects a register. Channel c (0..2) owns indices 4c..4c+3, in the order count, reload, compare 1, compare 2. Index 12 is control (10 bits), 13 is event state (9 bits) and 14 is mask (9 bits). Any other index, or an address whose low two bits are nonzero, reads zero and ignores writes.
- R3: Control bit 3c enables channel c. Bit 3c+1 selects its tick source (0 = every clock, 1 = external edge). Bit 3c+2 enables its wrap event. Bit 9 selects up-counting. A disabled channel keeps its count and raises no events.
- R4: When counting down, a tick decrements the count. A tick at zero loads the reload value instead, and if the wrap enable is set it records state bit 3c+2.
- R5: When counting up, a tick increments the count. A tick at all ones loads the reload value instead, and if the wrap enable is set it records state bit 3c+2.
- R6: A tick whose new count equals compare 1 records state bit 3c, and one whose new count equals compare 2 records state bit 3c+1. Neither depends on the wrap enable.
- R7: With the external source selected, a channel ticks once for each rising edge of `ext_tick[c]`, whatever the length of the high phase.
- R8: A bus write to a count register loads the written value and takes priority over a tick in the same cycle. That cycle raises no event for that channel.
- R9: Writing 1 to a state bit clears it. When an event occurs in the same cycle as a clear of its bit, the bit stays set.
- R10: `irq_out` is high exactly when some state bit is set and its mask bit is clear. Masked events are still recorded in the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| ext_tick | input | 3 | External tick level, one bit per channel |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two collisions matter here. A software clear of a state bit can land in the same cycle as the counter event that sets that bit. A software count write can land in the same cycle as a tick. The bench provokes the first by timing a write-1-to-clear so that it arrives on the exact edge where a down-counting channel reaches compare 1, and expects the bit to survive. It provokes the second by writing a count equal to compare 1 on a ticking channel, and expects the written value to appear with no compare event. A behavioural model in the bench follows every edge, so any mismatch in counts, state bits or the interrupt line is reported on the cycle where it first appears.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int BANK_WORDS  = 4;
  localparam int EVT_PER_CH  = 3;
  localparam int CTRL_PER_CH = 3;

  // control bit offsets within a channel's field
  localparam int CB_EN  = 0;
  localparam int CB_SRC = 1;
  localparam int CB_IE  = 2;

  // event bit offsets within a channel's field of the state register
  localparam int EV_M1  = 0;
  localparam int EV_M2  = 1;
  localparam int EV_OVF = 2;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CMP1   = 2'd2,
    SEL_CMP2   = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/tick_edge.sv
module tick_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tri_timer_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ch_en,
  input  logic         ch_src,
  input  logic         ovf_ie,
  input  logic         count_up,
  input  logic         ext_pulse,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] reload_o,
  output logic [W-1:0] cmp1_o,
  output logic [W-1:0] cmp2_o,
  output logic [EVT_PER_CH-1:0] evt_o
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ONE      = W'(1);

  function automatic logic at_limit(input logic [W-1:0] c, input logic up);
    return up ? (c == ALL_ONES) : (c == '0);
  endfunction

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic up);
    return up ? c + ONE : c - ONE;
  endfunction

  logic [W-1:0] cnt_q, reload_q, cmp1_q, cmp2_q, cnt_nxt;
  logic tick, cnt_wr, live, wrap;

  assign tick    = ch_en && (ch_src ? ext_pulse : 1'b1);
  assign cnt_wr  = wr_en && (bank_sel_e'(wr_sel) == SEL_COUNT);
  assign live    = tick && !cnt_wr;
  assign wrap    = at_limit(cnt_q, count_up);
  assign cnt_nxt = wrap ? reload_q : step(cnt_q, count_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      cmp1_q   <= '0;
      cmp2_q   <= '0;
    end else begin
      if (cnt_wr)    cnt_q <= wr_data;
      else if (tick) cnt_q <= cnt_nxt;
      if (wr_en) begin
        case (bank_sel_e'(wr_sel))
          SEL_RELOAD: reload_q <= wr_data;
          SEL_CMP1:   cmp1_q   <= wr_data;
          SEL_CMP2:   cmp2_q   <= wr_data;
          default:    ;
        endcase
      end
    end
  end

  assign evt_o[EV_M1]  = live && (cnt_nxt == cmp1_q);
  assign evt_o[EV_M2]  = live && (cnt_nxt == cmp2_q);
  assign evt_o[EV_OVF] = live && wrap && ovf_ie;

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign cmp1_o   = cmp1_q;
  assign cmp2_o   = cmp2_q;

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

  // R4
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !count_up && cnt_q == '0) |=> (cnt_q == $past(reload_q)));

  // R8
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data)));

  // R6
  cmp1_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[EV_M1] |=> (cnt_q == $past(cmp1_q)));
endmodule

// File: rtl/tri_timer.sv
module tri_timer import tri_timer_pkg::*; #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] ext_tick,
  output logic              irq_out
);
  localparam int EVT_W     = EVT_PER_CH * NUM_CH;
  localparam int CTRL_W    = CTRL_PER_CH * NUM_CH + 1;
  localparam int DIR_BIT   = CTRL_W - 1;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int CTRL_IDX  = BANK_WORDS * NUM_CH;
  localparam int STATE_IDX = CTRL_IDX + 1;
  localparam int MASK_IDX  = CTRL_IDX + 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic [CTRL_W-1:0] ctrl_q;
  logic [EVT_W-1:0]  state_q, mask_q, evt_vec, state_clr;
  logic [NUM_CH-1:0] ext_pulse;
  logic [CNT_W-1:0]  ch_cnt [NUM_CH];
  logic [CNT_W-1:0]  ch_rel [NUM_CH];
  logic [CNT_W-1:0]  ch_c1  [NUM_CH];
  logic [CNT_W-1:0]  ch_c2  [NUM_CH];

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  tick_edge #(.N(NUM_CH)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (ext_tick),
    .pulse_o (ext_pulse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic bank_we;
    assign bank_we = bus_we && aligned && (int'(idx[IDX_W-1:2]) == c);

    tmr_channel #(.W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_en     (ctrl_q[c*CTRL_PER_CH + CB_EN]),
      .ch_src    (ctrl_q[c*CTRL_PER_CH + CB_SRC]),
      .ovf_ie    (ctrl_q[c*CTRL_PER_CH + CB_IE]),
      .count_up  (ctrl_q[DIR_BIT]),
      .ext_pulse (ext_pulse[c]),
      .wr_en     (bank_we),
      .wr_sel    (idx[1:0]),
      .wr_data   (bus_wdata),
      .cnt_o     (ch_cnt[c]),
      .reload_o  (ch_rel[c]),
      .cmp1_o    (ch_c1[c]),
      .cmp2_o    (ch_c2[c]),
      .evt_o     (evt_vec[c*EVT_PER_CH +: EVT_PER_CH])
    );
  end

  assign state_clr = (bus_we && aligned && int'(idx) == STATE_IDX)
                     ? bus_wdata[EVT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      state_q <= '0;
      mask_q  <= '0;
    end else begin
      if (bus_we && aligned && int'(idx) == CTRL_IDX) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (bus_we && aligned && int'(idx) == MASK_IDX) mask_q <= bus_wdata[EVT_W-1:0];
      state_q <= (state_q & ~state_clr) | evt_vec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(idx[IDX_W-1:2]) == c) begin
          case (bank_sel_e'(idx[1:0]))
            SEL_COUNT:  bus_rdata = ch_cnt[c];
            SEL_RELOAD: bus_rdata = ch_rel[c];
            SEL_CMP1:   bus_rdata = ch_c1[c];
            default:    bus_rdata = ch_c2[c];
          endcase
        end
      end
      if (int'(idx) == CTRL_IDX)  bus_rdata = CNT_W'(ctrl_q);
      if (int'(idx) == STATE_IDX) bus_rdata = CNT_W'(state_q);
      if (int'(idx) == MASK_IDX)  bus_rdata = CNT_W'(mask_q);
    end
  end

  assign irq_out = |(state_q & ~mask_q);

  // R9
  evt_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((state_q & $past(evt_vec)) == $past(evt_vec)));
endmodule

// File: tb/tb_tri_timer.sv
`timescale 1ns/1ps
module tb_tri_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  ext_tick = 3'b000;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tri_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .irq_out(irq_out)
  );

  // behavioural reference
  logic [31:0] m_cnt [3];
  logic [31:0] m_rel [3];
  logic [31:0] m_c1  [3];
  logic [31:0] m_c2  [3];
  logic [9:0]  m_ctrl;
  logic [8:0]  m_st, m_mk;
  logic [2:0]  m_ext;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = 0; m_rel[c] = 0; m_c1[c] = 0; m_c2[c] = 0;
      end
      m_ctrl = 0; m_st = 0; m_mk = 0; m_ext = 0;
    end else begin
      logic [8:0] ev;
      logic [31:0] nc;
      int w;
      ev = 0;
      w = (bus_addr[1:0] == 0) ? int'(bus_addr >> 2) : 99;
      for (int c = 0; c < 3; c++) begin
        bit en, src, ie, up, tk;
        en  = m_ctrl[3*c];
        src = m_ctrl[3*c+1];
        ie  = m_ctrl[3*c+2];
        up  = m_ctrl[9];
        tk  = en && (!src || (ext_tick[c] && !m_ext[c]));
        if (bus_we && w == 4*c) nc = bus_wdata;
        else if (tk) begin
          if ((up && m_cnt[c] == 32'hFFFF_FFFF) || (!up && m_cnt[c] == 0)) begin
            nc = m_rel[c];
            if (ie) ev[3*c+2] = 1;
          end else nc = up ? m_cnt[c] + 1 : m_cnt[c] - 1;
          if (nc == m_c1[c]) ev[3*c] = 1;
          if (nc == m_c2[c]) ev[3*c+1] = 1;
        end else nc = m_cnt[c];
        m_cnt[c] = nc;
      end
      if (bus_we) begin
        if (w < 12 && w % 4 == 1) m_rel[w/4] = bus_wdata;
        if (w < 12 && w % 4 == 2) m_c1[w/4]  = bus_wdata;
        if (w < 12 && w % 4 == 3) m_c2[w/4]  = bus_wdata;
        if (w == 12) m_ctrl = bus_wdata[9:0];
        if (w == 14) m_mk   = bus_wdata[8:0];
        if (w == 13) m_st   = m_st & ~bus_wdata[8:0];
      end
      m_st  = m_st | ev;
      m_ext = ext_tick;
    end
  end

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    int w;
    if (a[1:0] != 0) return 0;
    w = int'(a >> 2);
    if (w < 12) begin
      case (w % 4)
        0: return m_cnt[w/4];
        1: return m_rel[w/4];
        2: return m_c1[w/4];
        default: return m_c2[w/4];
      endcase
    end
    if (w == 12) return 32'(m_ctrl);
    if (w == 13) return 32'(m_st);
    if (w == 14) return 32'(m_mk);
    return 0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    int w;
    w = int'(a >> 2);
    if (a[1:0] != 0 || w > 14) return "R2";
    if (w < 12) return (w % 4 == 0) ? "R4" : "R2";
    if (w == 12) return "R3";
    if (w == 13) return "R9";
    return "R10";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] e;
      e = model_rd(bus_addr);
      chk(bus_rdata == e, tag_of(bus_addr), bus_rdata, e);
      chk(irq_out == |(m_st & ~m_mk), "R10", 32'(irq_out), 32'(|(m_st & ~m_mk)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    bus_addr = a;
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] m,
                           input logic [31:0] e, input string tag);
    bus_addr = a; #1;
    chk((bus_rdata & m) == e, tag, bus_rdata & m, e);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    for (int a = 0; a < 15; a++) expect_rd(8'(a * 4), 32'hFFFF_FFFF, 0, "R1");
    chk(irq_out == 1'b0, "R1", 32'(irq_out), 0);

    // R2: map, widths, undefined offsets
    wr(8'h14, 32'h1234_5678);
    expect_rd(8'h14, 32'hFFFF_FFFF, 32'h1234_5678, "R2");
    wr(8'h2C, 32'hCAFE_0001);
    expect_rd(8'h2C, 32'hFFFF_FFFF, 32'hCAFE_0001, "R2");
    wr(8'h38, 32'hFFFF_FFFF);
    expect_rd(8'h38, 32'hFFFF_FFFF, 32'h0000_01FF, "R2");
    wr(8'h38, 32'h0);
    wr(8'h3C, 32'hFFFF_FFFF);
    expect_rd(8'h3C, 32'hFFFF_FFFF, 0, "R2");
    expect_rd(8'h15, 32'hFFFF_FFFF, 0, "R2");
    wr(8'h31, 32'h0000_0001);
    expect_rd(8'h30, 32'hFFFF_FFFF, 0, "R2");

    // R4 / R6: channel 0 down with reload and compare 1
    wr(8'h04, 32'd3);
    wr(8'h08, 32'd2);
    wr(8'h00, 32'd5);
    wr(8'h30, 32'h0000_0005);
    idle(20, 8'h00);
    expect_rd(8'h34, 32'h5, 32'h5, "R4");

    // R5: up counting through all ones
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h1FF);
    wr(8'h00, 32'hFFFF_FFFD);
    wr(8'h04, 32'd7);
    wr(8'h0C, 32'd8);
    wr(8'h30, 32'h0000_0205);
    idle(6, 8'h00);
    expect_rd(8'h34, 32'h6, 32'h6, "R5");
    expect_rd(8'h34, 32'h1, 32'h0, "R6");

    // R7: external tick on channel 1
    wr(8'h30, 32'h0000_0018);
    wr(8'h10, 32'd100);
    ext_tick[1] = 1'b1;
    idle(5, 8'h10);
    ext_tick[1] = 1'b0;
    idle(5, 8'h10);
    expect_rd(8'h10, 32'hFFFF_FFFF, 32'd99, "R7");
    ext_tick[1] = 1'b1; idle(1, 8'h10);
    ext_tick[1] = 1'b0; idle(2, 8'h10);
    expect_rd(8'h10, 32'hFFFF_FFFF, 32'd98, "R7");

    // R8: count write on a ticking channel 2
    wr(8'h30, 32'h0000_0058);
    wr(8'h20, 32'd1000);
    expect_rd(8'h20, 32'hFFFF_FFFF, 32'd1000, "R8");
    wr(8'h28, 32'd500);
    wr(8'h34, 32'h1FF);
    wr(8'h20, 32'd500);
    expect_rd(8'h20, 32'hFFFF_FFFF, 32'd500, "R8");
    idle(2, 8'h20);
    expect_rd(8'h34, 32'h40, 32'h0, "R8");

    // R3: disabled channel holds
    wr(8'h30, 32'h0000_0018);
    expect_rd(8'h20, 32'h0, 32'h0, "R3");
    held = bus_rdata;
    idle(10, 8'h20);
    expect_rd(8'h20, 32'hFFFF_FFFF, held, "R3");

    // R9: clear colliding with a compare event
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h1FF);
    wr(8'h08, 32'd5);
    wr(8'h30, 32'h0000_0001);
    wr(8'h00, 32'd10);
    idle(4, 8'h00);
    wr(8'h34, 32'h1);
    expect_rd(8'h34, 32'h1, 32'h1, "R9");
    wr(8'h34, 32'h1);
    expect_rd(8'h34, 32'h1, 32'h0, "R9");

    // R10: mask suppresses the line, state still records
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h1FF);
    wr(8'h38, 32'h1FF);
    wr(8'h08, 32'd20);
    wr(8'h00, 32'd22);
    wr(8'h30, 32'h0000_0001);
    idle(3, 8'h34);
    wr(8'h30, 32'h0);
    expect_rd(8'h34, 32'h1, 32'h1, "R10");
    chk(irq_out == 1'b0, "R10", 32'(irq_out), 0);
    wr(8'h38, 32'h0);
    #1 chk(irq_out == 1'b1, "R10", 32'(irq_out), 1);
    wr(8'h34, 32'h1FF);
    #1 chk(irq_out == 1'b0, "R10", 32'(irq_out), 0);

    idle(4, 8'h34);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule